// File: doc/BRIEF.md
# Supply brownout status register

This block is a 16-bit read-only status word that reports the two supply monitors and holds a set of sticky event flags. Two bits follow the brownout comparators of the core supply and the I/O supply. Each comparator output is asynchronous, so it is re-timed before use. A monitor that is switched off forces its level bit to zero. A falling level on an enabled monitor records a brownout event in a sticky flag. Four more sticky flags collect single-cycle pulses from the oscillator and ADC logic.

Software reads the word through a read strobe qualified by an address match. The read data is registered and appears one cycle after the strobe. That read clears every sticky flag, while the two live level bits stay as they are. Each brownout flag drives an interrupt line when the matching interrupt enable is set. Power-on reset clears everything. The general system reset clears only the ADC-overrun flag.

Top module: `supply_status_reg`

## Requirements
- R1: Bit 15 shows the I/O-supply comparator after synchronization. It is 1 when the comparator is high and the I/O monitor is enabled, and it is 0 whenever `mon_io_en` is 0. A change on the comparator input reaches the bit within three rising clock edges.
- R2: Bit 14 behaves like R1 for the core-supply comparator, gated by `mon_core_en`.
- R3: Bits 13, 12, 10, 9, 8, 7, 3 and 0 always read 0.
- R4: Bit 5 (I/O) and bit 4 (core) are sticky brownout flags. Each is set when its synchronized comparator level falls from 1 to 0 while its monitor is enabled. A fall while the monitor is disabled sets nothing.
- R5: `irq_io` equals bit 5 AND `irq_io_en`, and `irq_core` equals bit 4 AND `irq_core_en`.
- R6: A read with `rd_stb`=1 and `rd_addr`=`REG_ADDR` returns the word as it stood before that clock edge. The same edge clears bits 11, 6, 5, 4, 2 and 1. Bits 15 and 14 are unaffected by the read.
- R7: If a flag's set event falls in the same cycle as a clearing read, the flag is 1 afterwards, and that read returns the flag's earlier value.
- R8: A one-cycle pulse sets its sticky flag: `osc_ready_pulse` sets bit 11, `osc_fail_pulse` sets bit 6, `adc_ovr_pulse` sets bit 2 and `adc_rdy_pulse` sets bit 1.
- R9: `sys_rst` clears bit 2 only, and all other bits keep their values. `por_rst` clears every bit and the read data.
- R10: `rd_data` is 0 in any cycle after an edge without a matching read. A strobe with another address neither returns data nor clears any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | General system reset, synchronous, active high |
| cmp_io_async | input | 1 | I/O-supply comparator output, asynchronous |
| cmp_core_async | input | 1 | Core-supply comparator output, asynchronous |
| mon_io_en | input | 1 | I/O monitor enable |
| mon_core_en | input | 1 | Core monitor enable |
| irq_io_en | input | 1 | I/O brownout interrupt enable |
| irq_core_en | input | 1 | Core brownout interrupt enable |
| osc_ready_pulse | input | 1 | Oscillator-ready event pulse |
| osc_fail_pulse | input | 1 | Oscillator-failure event pulse |
| adc_ovr_pulse | input | 1 | ADC-overrun event pulse |
| adc_rdy_pulse | input | 1 | ADC data-ready event pulse |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Registered read data |
| irq_io | output | 1 | I/O brownout interrupt |
| irq_core | output | 1 | Core brownout interrupt |

## Verification
A flag's set event and a clearing read can land in the same clock cycle. The bench provokes this by raising an ADC data-ready pulse on the same edge as a matching read strobe. It expects that read to return the flag as 0 and the next read to return it as 1. A system reset that arrives while flags are set is judged the same way. Only the overrun bit may drop, and a later read shows the others intact.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
  localparam int WORD_W = 16;

  localparam int B_LVL_IO   = 15;
  localparam int B_LVL_CORE = 14;
  localparam int B_OSC_RDY  = 11;
  localparam int B_OSC_FAIL = 6;
  localparam int B_BO_IO    = 5;
  localparam int B_BO_CORE  = 4;
  localparam int B_ADC_OVR  = 2;
  localparam int B_ADC_RDY  = 1;

  // flag bank slot order
  typedef enum logic [2:0] {
    F_ADC_RDY  = 3'd0,
    F_ADC_OVR  = 3'd1,
    F_BO_CORE  = 3'd2,
    F_BO_IO    = 3'd3,
    F_OSC_FAIL = 3'd4,
    F_OSC_RDY  = 3'd5
  } flag_slot_e;

  localparam int NUM_FLAGS = 6;
  localparam int NUM_MON   = 2;
  localparam int MON_CORE  = 0;
  localparam int MON_IO    = 1;

  // flags that the system reset also clears
  localparam logic [NUM_FLAGS-1:0] SYS_CLR_MASK = 6'b000010;

  localparam logic [WORD_W-1:0] RSV_MASK = 16'h3789;
endpackage

// File: rtl/sstat_sync.sv
module sstat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sstat_level_mon.sv
module sstat_level_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_rst,
  input  logic cmp_async,
  input  logic mon_en,
  output logic level,
  output logic fall_evt
);
  logic synced;
  logic synced_d;
  logic level_q;

  sstat_sync #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (por_rst),
    .d_async (cmp_async),
    .q       (synced)
  );

  always_ff @(posedge clk) begin
    if (por_rst) begin
      synced_d <= 1'b0;
      level_q  <= 1'b0;
    end else begin
      synced_d <= synced;
      level_q  <= synced & mon_en;
    end
  end

  assign level    = level_q;
  assign fall_evt = synced_d & ~synced & mon_en;

  // R1 / R2: a disabled monitor reports a low level on the next cycle
  assert_level_off_R1: assert property (@(posedge clk) disable iff (por_rst)
    !mon_en |=> !level);
endmodule

// File: rtl/sstat_flag_bank.sv
module sstat_flag_bank #(
  parameter int                N        = 6,
  parameter logic [N-1:0]      SYS_MASK = '0
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         sys_rst,
  input  logic [N-1:0] set_evt,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    if (SYS_MASK[i]) begin : g_sys
      always_ff @(posedge clk) begin
        if (por_rst || sys_rst) q <= 1'b0;
        else if (set_evt[i])    q <= 1'b1;
        else if (rd_clr)        q <= 1'b0;
      end
      assert_sysrst_clears_R9: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst |=> !q);
    end else begin : g_por
      always_ff @(posedge clk) begin
        if (por_rst)         q <= 1'b0;
        else if (set_evt[i]) q <= 1'b1;
        else if (rd_clr)     q <= 1'b0;
      end
      assert_sysrst_keeps_R9: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst && q && !rd_clr && !set_evt[i] |=> q);
    end
    assign flags[i] = q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
      set_evt[i] |=> q);
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
      rd_clr && !set_evt[i] |=> !q);
  end
endmodule

// File: rtl/supply_status_reg.sv
module supply_status_reg
  import sstat_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h0B,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic              cmp_io_async,
  input  logic              cmp_core_async,
  input  logic              mon_io_en,
  input  logic              mon_core_en,
  input  logic              irq_io_en,
  input  logic              irq_core_en,
  input  logic              osc_ready_pulse,
  input  logic              osc_fail_pulse,
  input  logic              adc_ovr_pulse,
  input  logic              adc_rdy_pulse,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_io,
  output logic              irq_core
);
  logic [NUM_MON-1:0]   cmp_vec;
  logic [NUM_MON-1:0]   en_vec;
  logic [NUM_MON-1:0]   lvl_vec;
  logic [NUM_MON-1:0]   fall_vec;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic [WORD_W-1:0]    status_word;
  logic                 rd_hit;

  assign cmp_vec[MON_CORE] = cmp_core_async;
  assign cmp_vec[MON_IO]   = cmp_io_async;
  assign en_vec[MON_CORE]  = mon_core_en;
  assign en_vec[MON_IO]    = mon_io_en;

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    sstat_level_mon #(.STAGES(SYNC_STAGES)) u_mon (
      .clk       (clk),
      .por_rst   (por_rst),
      .cmp_async (cmp_vec[m]),
      .mon_en    (en_vec[m]),
      .level     (lvl_vec[m]),
      .fall_evt  (fall_vec[m])
    );
  end

  always_comb begin
    set_vec             = '0;
    set_vec[F_ADC_RDY]  = adc_rdy_pulse;
    set_vec[F_ADC_OVR]  = adc_ovr_pulse;
    set_vec[F_BO_CORE]  = fall_vec[MON_CORE];
    set_vec[F_BO_IO]    = fall_vec[MON_IO];
    set_vec[F_OSC_FAIL] = osc_fail_pulse;
    set_vec[F_OSC_RDY]  = osc_ready_pulse;
  end

  assign rd_hit = rd_stb && (rd_addr == REG_ADDR);

  sstat_flag_bank #(.N(NUM_FLAGS), .SYS_MASK(SYS_CLR_MASK)) u_flags (
    .clk     (clk),
    .por_rst (por_rst),
    .sys_rst (sys_rst),
    .set_evt (set_vec),
    .rd_clr  (rd_hit),
    .flags   (flag_vec)
  );

  always_comb begin
    status_word             = '0;
    status_word[B_LVL_IO]   = lvl_vec[MON_IO];
    status_word[B_LVL_CORE] = lvl_vec[MON_CORE];
    status_word[B_OSC_RDY]  = flag_vec[F_OSC_RDY];
    status_word[B_OSC_FAIL] = flag_vec[F_OSC_FAIL];
    status_word[B_BO_IO]    = flag_vec[F_BO_IO];
    status_word[B_BO_CORE]  = flag_vec[F_BO_CORE];
    status_word[B_ADC_OVR]  = flag_vec[F_ADC_OVR];
    status_word[B_ADC_RDY]  = flag_vec[F_ADC_RDY];
  end

  always_ff @(posedge clk) begin
    if (por_rst)     rd_data <= '0;
    else if (rd_hit) rd_data <= status_word;
    else             rd_data <= '0;
  end

  assign irq_io   = flag_vec[F_BO_IO]   & irq_io_en;
  assign irq_core = flag_vec[F_BO_CORE] & irq_core_en;

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (por_rst)
    (rd_data & RSV_MASK) == '0);
  assert_read_snapshot_R6: assert property (@(posedge clk) disable iff (por_rst)
    rd_hit |=> rd_data == $past(status_word));
  assert_idle_data_R10: assert property (@(posedge clk) disable iff (por_rst)
    !rd_hit |=> rd_data == '0);
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (por_rst)
    rd_hit && $stable(cmp_vec) && $stable(en_vec) && $stable(lvl_vec) |=> lvl_vec == $past(lvl_vec));
endmodule

// File: tb/sim_supply_status_reg.sv
module sim_supply_status_reg;
  localparam logic [7:0] ADDR = 8'h0B;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1, sys_rst = 1'b0;
  logic        cmp_io_async = 1'b0, cmp_core_async = 1'b0;
  logic        mon_io_en = 1'b0, mon_core_en = 1'b0;
  logic        irq_io_en = 1'b0, irq_core_en = 1'b0;
  logic        osc_ready_pulse = 1'b0, osc_fail_pulse = 1'b0;
  logic        adc_ovr_pulse = 1'b0, adc_rdy_pulse = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [15:0] rd_data;
  logic        irq_io, irq_core;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  supply_status_reg u0 (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .cmp_io_async(cmp_io_async), .cmp_core_async(cmp_core_async),
    .mon_io_en(mon_io_en), .mon_core_en(mon_core_en),
    .irq_io_en(irq_io_en), .irq_core_en(irq_core_en),
    .osc_ready_pulse(osc_ready_pulse), .osc_fail_pulse(osc_fail_pulse),
    .adc_ovr_pulse(adc_ovr_pulse), .adc_rdy_pulse(adc_rdy_pulse),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_io(irq_io), .irq_core(irq_core)
  );

  // pulses {osc_ready, osc_fail, adc_ovr, adc_rdy} , expected word
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0001, 16'h0002},
    {4'b0010, 16'h0004},
    {4'b0100, 16'h0040},
    {4'b1000, 16'h0800},
    {4'b1111, 16'h0846},
    {4'b0101, 16'h0042}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] v);
    rd_stb  = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_stb  = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse(input logic [3:0] p);
    {osc_ready_pulse, osc_fail_pulse, adc_ovr_pulse, adc_rdy_pulse} = p;
    @(negedge clk);
    {osc_ready_pulse, osc_fail_pulse, adc_ovr_pulse, adc_rdy_pulse} = 4'b0;
  endtask

  task automatic por();
    por_rst = 1'b1;
    wait_cyc(2);
    por_rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    @(negedge clk);
    por();
    check("R9 reset rd_data", rd_data, 16'h0000);
    do_read(ADDR, v);
    check("R3 reset read", v, 16'h0000);

    // table walk: event flags, then cleared by the read
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][19:16]);
      do_read(ADDR, v);
      check("R8 event flags", v, VEC[i][15:0]);
      do_read(ADDR, v);
      check("R6 flags cleared", v, 16'h0000);
    end

    // R1 / R2 level bits
    mon_io_en = 1'b1; cmp_io_async = 1'b1;
    wait_cyc(4);
    do_read(ADDR, v);
    check("R1 io level", v, 16'h8000);
    do_read(ADDR, v);
    check("R6 level survives read", v, 16'h8000);
    mon_core_en = 1'b1; cmp_core_async = 1'b1;
    wait_cyc(4);
    do_read(ADDR, v);
    check("R2 core level", v, 16'hC000);

    // R4 / R5 io brownout with interrupt enabled
    irq_io_en = 1'b1;
    cmp_io_async = 1'b0;
    wait_cyc(4);
    check("R5 irq_io raised", {15'b0, irq_io}, 16'h0001);
    do_read(ADDR, v);
    check("R4 io brownout flag", v, 16'h4020);
    check("R5 irq_io cleared by read", {15'b0, irq_io}, 16'h0000);

    // core brownout with interrupt disabled
    cmp_core_async = 1'b0;
    wait_cyc(4);
    check("R5 irq_core gated", {15'b0, irq_core}, 16'h0000);
    irq_core_en = 1'b1;
    @(negedge clk);
    check("R5 irq_core enabled", {15'b0, irq_core}, 16'h0001);
    do_read(ADDR, v);
    check("R4 core brownout flag", v, 16'h0010);

    // R4 fall with monitor disabled records nothing; R1 disabled level
    mon_io_en = 1'b0; cmp_io_async = 1'b1;
    wait_cyc(4);
    do_read(ADDR, v);
    check("R1 disabled level low", v, 16'h0000);
    cmp_io_async = 1'b0;
    wait_cyc(4);
    do_read(ADDR, v);
    check("R4 no flag when disabled", v, 16'h0000);

    // R7 set and clearing read in the same cycle
    adc_rdy_pulse = 1'b1;
    do_read(ADDR, v);
    adc_rdy_pulse = 1'b0;
    check("R7 same-cycle read value", v, 16'h0000);
    do_read(ADDR, v);
    check("R7 flag kept", v, 16'h0002);

    // R10 non-matching address
    pulse(4'b0100);
    do_read(8'h0C, v);
    check("R10 wrong addr data", v, 16'h0000);
    do_read(ADDR, v);
    check("R10 flag not cleared", v, 16'h0040);

    // R9 system reset clears only the overrun flag
    pulse(4'b1111);
    mon_core_en = 1'b1; cmp_core_async = 1'b1;
    wait_cyc(4);
    cmp_core_async = 1'b0;
    wait_cyc(4);
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    do_read(ADDR, v);
    check("R9 sys reset keeps others", v, 16'h0852);

    // R9 power-on reset clears all
    pulse(4'b1111);
    mon_core_en = 1'b1; cmp_core_async = 1'b1;
    wait_cyc(4);
    por();
    check("R9 por clears rd_data", rd_data, 16'h0000);
    cmp_core_async = 1'b0; mon_core_en = 1'b0;
    do_read(ADDR, v);
    check("R9 por clears flags", v, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule